// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Cell

This block is one configurable logic cell of the sum-of-products kind. A set of input signals plus one feedback signal is expanded into true and complemented literals. Eight product terms each AND a chosen subset of those literals. The terms that are switched on are ORed together, and the result can optionally be inverted. The cell then either drives that value straight to its pin or stores it in a one-bit register. The register can be set up as a D or T element, clocked on either edge, and clocked from a shared clock or from a clock formed by its own product term.

Three further product terms, built from the same literals, provide an asynchronous register clear, a pin output enable and the local clock. All behaviour comes from static configuration ports, so a system instantiates many cells and ties each one's configuration to constants or to a configuration store. The feedback literal carries either the register state or the value seen on the pin.

The register has two named behaviours, which are the states of its next-state logic. STORE_D loads the polarity-adjusted sum. STORE_T flips when that sum is 1 and holds when it is 0. The single transition, from the current value to the next, happens on the active edge of the selected clock. A clear overrides it and sends the register to 0.

Top module: `macrocell_pt`

## Requirements
- R1: Literal 2*i is signal i and literal 2*i+1 is its complement. Signals 0..N_IN-1 are `in_sig`, and signal N_IN is the feedback. Product term k uses mask bits `cfg_sum_mask[k*2*(N_IN+1) +: 2*(N_IN+1)]`. It is the AND of the selected literals, and a term with an empty mask is 1.
- R2: The sum is the OR of the product terms whose `cfg_sum_use` bit is 1. A term whose use bit is 0 contributes 0 whatever its mask.
- R3: With `cfg_invert`=1 the sum is complemented before it reaches the output or the register.
- R4: With `cfg_registered`=0, `pin_out` follows the polarity-adjusted sum with no clock edge.
- R5: With `cfg_registered`=1 and `cfg_toggle`=0, the register loads the polarity-adjusted sum on the active edge and holds between edges. `pin_out` shows the register.
- R6: With `cfg_toggle`=1, the register flips on an active edge when the polarity-adjusted sum is 1 and holds when it is 0.
- R7: `cfg_neg_edge`=0 makes the rising edge of the selected clock active. `cfg_neg_edge`=1 makes the falling edge active.
- R8: With `cfg_clk_local`=1, the register is clocked by the product term set in `cfg_clk_mask`, and `clk_g` edges have no effect.
- R9: When `cfg_clr_use`=1 and the term in `cfg_clr_mask` is 1, the register goes to 0 at once and stays 0 through active edges. With `cfg_clr_use`=0 that term has no effect.
- R10: With `cfg_oe_use`=1, `pin_oe` equals the term in `cfg_oe_mask`. With `cfg_oe_use`=0, `pin_oe` is 1.
- R11: The feedback literal is the register state when `cfg_fb_pin`=0 and `pin_in` when `cfg_fb_pin`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_g | input | 1 | Shared clock |
| in_sig | input | N_IN | Input signals to the array |
| pin_in | input | 1 | Value seen on the pin, usable as feedback |
| cfg_sum_mask | input | N_PT*2*(N_IN+1) | Literal selection for the eight sum terms |
| cfg_sum_use | input | N_PT | Per-term enable into the OR |
| cfg_invert | input | 1 | Complement the sum |
| cfg_registered | input | 1 | 1 selects registered output, 0 combinational |
| cfg_toggle | input | 1 | 1 selects T behaviour, 0 selects D |
| cfg_neg_edge | input | 1 | 1 selects the falling clock edge |
| cfg_clk_local | input | 1 | 1 clocks the register from the clock term |
| cfg_clk_mask | input | 2*(N_IN+1) | Literal selection for the clock term |
| cfg_clr_use | input | 1 | Enables the clear term |
| cfg_clr_mask | input | 2*(N_IN+1) | Literal selection for the clear term |
| cfg_oe_use | input | 1 | 1 takes the output enable from its term |
| cfg_oe_mask | input | 2*(N_IN+1) | Literal selection for the output-enable term |
| cfg_fb_pin | input | 1 | 1 feeds back the pin, 0 the register |
| pin_out | output | 1 | Cell output value |
| pin_oe | output | 1 | Output enable for the pin driver |

## Verification
The combinational path is swept over every combination of the four inputs and the pin value under several mask sets. One set has every term disabled, which separates the use bits from the masks. A term with an empty mask shows the AND identity. A three-input odd-parity cover is compared against arithmetic parity, which shows that the literal order and the complement placement are right. Hashed masks that include the feedback literal, each with and without inversion, show the pin feedback path and the polarity. Bit sequences applied to the register show D loading against T flipping, rising against falling edges, and the shared clock against the local term clock. A clear held across clock edges, and then disabled, shows the clear's priority. A register-fed inverting term shows the register feedback as a divide-by-two.

// File: rtl/macrocell_pkg.sv
`timescale 1ns/1ps
package macrocell_pkg;

    // Register next-state behaviour
    typedef enum logic {
        STORE_D = 1'b0,
        STORE_T = 1'b1
    } store_mode_e;

    // Register clock source
    typedef enum logic {
        CLK_GLOBAL = 1'b0,
        CLK_LOCAL  = 1'b1
    } clk_src_e;

    // Pin value source
    typedef enum logic {
        OUT_COMB = 1'b0,
        OUT_REG  = 1'b1
    } out_mode_e;

    // Feedback literal source
    typedef enum logic {
        FB_REG = 1'b0,
        FB_PIN = 1'b1
    } fb_src_e;

    // Positions of the dedicated control terms
    localparam int N_CTRL = 3;
    localparam int CT_CLR = 0;
    localparam int CT_OE  = 1;
    localparam int CT_CLK = 2;

endpackage

// File: rtl/mc_pterm_array.sv
`timescale 1ns/1ps
module mc_pterm_array #(
    parameter int N_SIG   = 5,
    parameter int N_TERMS = 8,
    localparam int NLIT   = 2 * N_SIG
) (
    input  logic [N_SIG-1:0]        sig,
    input  logic [N_TERMS*NLIT-1:0] mask,
    output logic [N_TERMS-1:0]      term
);

    logic [NLIT-1:0] lit;

    // Even literal: signal, odd literal: its complement
    for (genvar s = 0; s < N_SIG; s++) begin : g_lit
        assign lit[2*s]   = sig[s];
        assign lit[2*s+1] = ~sig[s];
    end

    // Unselected literals are forced to 1 so they drop out of the AND
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
        assign term[t] = &(lit | ~mask[t*NLIT +: NLIT]);
    end

endmodule

// File: rtl/mc_storage.sv
`timescale 1ns/1ps
module mc_storage
    import macrocell_pkg::*;
(
    input  logic        clk_g,
    input  logic        clk_term,
    input  clk_src_e    clk_src,
    input  logic        neg_edge,
    input  store_mode_e mode,
    input  logic        d,
    input  logic        clr,
    output logic        q
);

    logic src_clk;
    logic reg_clk;
    logic q_nxt;
    logic seen_clear;

    always_comb begin
        unique case (clk_src)
            CLK_GLOBAL: src_clk = clk_g;
            CLK_LOCAL:  src_clk = clk_term;
        endcase
    end

    // Falling-edge operation by inverting the selected clock
    assign reg_clk = src_clk ^ neg_edge;

    // Next-state logic: STORE_D loads, STORE_T flips on 1
    always_comb begin
        unique case (mode)
            STORE_D: q_nxt = d;
            STORE_T: q_nxt = q ^ d;
        endcase
    end

    // State register with asynchronous clear taking priority
    always_ff @(posedge reg_clk or posedge clr) begin
        if (clr) begin
            q          <= 1'b0;
            seen_clear <= 1'b1;
        end else begin
            q          <= q_nxt;
        end
    end

    // Clear holds the register at 0 whenever it is active
    p_clear_holds_zero_r9: assert property (
        @(posedge clk_g) disable iff (seen_clear !== 1'b1)
        clr |-> (q == 1'b0));

    // D load on the shared rising edge
    p_d_load_r5: assert property (
        @(posedge clk_g) disable iff (seen_clear !== 1'b1)
        (clk_src == CLK_GLOBAL && !neg_edge && mode == STORE_D && !clr)
        |=> (clr || !$stable({clk_src, neg_edge, mode}) || q == $past(d)));

    // T flip on the shared rising edge
    p_t_flip_r6: assert property (
        @(posedge clk_g) disable iff (seen_clear !== 1'b1)
        (clk_src == CLK_GLOBAL && !neg_edge && mode == STORE_T && !clr)
        |=> (clr || !$stable({clk_src, neg_edge, mode}) || q == ($past(q) ^ $past(d))));

endmodule

// File: rtl/mc_output.sv
`timescale 1ns/1ps
module mc_output
    import macrocell_pkg::*;
(
    input  logic      sum_pol,
    input  logic      q,
    input  out_mode_e out_mode,
    input  logic      oe_use,
    input  logic      oe_term,
    input  fb_src_e   fb_src,
    input  logic      pin_in,
    output logic      pin_out,
    output logic      pin_oe,
    output logic      fb
);

    always_comb begin
        unique case (out_mode)
            OUT_COMB: pin_out = sum_pol;
            OUT_REG:  pin_out = q;
        endcase
    end

    assign pin_oe = oe_use ? oe_term : 1'b1;

    // Kept apart from the pin mux so the feedback never depends on the sum
    always_comb begin
        unique case (fb_src)
            FB_REG: fb = q;
            FB_PIN: fb = pin_in;
        endcase
    end

endmodule

// File: rtl/macrocell_pt.sv
`timescale 1ns/1ps
module macrocell_pt
    import macrocell_pkg::*;
#(
    parameter int N_IN  = 4,
    parameter int N_PT  = 8,
    localparam int N_SIG = N_IN + 1,
    localparam int NLIT  = 2 * N_SIG
) (
    input  logic                 clk_g,
    input  logic [N_IN-1:0]      in_sig,
    input  logic                 pin_in,
    input  logic [N_PT*NLIT-1:0] cfg_sum_mask,
    input  logic [N_PT-1:0]      cfg_sum_use,
    input  logic                 cfg_invert,
    input  logic                 cfg_registered,
    input  logic                 cfg_toggle,
    input  logic                 cfg_neg_edge,
    input  logic                 cfg_clk_local,
    input  logic [NLIT-1:0]      cfg_clk_mask,
    input  logic                 cfg_clr_use,
    input  logic [NLIT-1:0]      cfg_clr_mask,
    input  logic                 cfg_oe_use,
    input  logic [NLIT-1:0]      cfg_oe_mask,
    input  logic                 cfg_fb_pin,
    output logic                 pin_out,
    output logic                 pin_oe
);

    logic                   fb;
    logic [N_SIG-1:0]       sig;
    logic [N_PT-1:0]        sum_term;
    logic [N_CTRL-1:0]      ctrl_term;
    logic [N_CTRL*NLIT-1:0] ctrl_mask;
    logic                   sum_or;
    logic                   sum_pol;
    logic                   clr_act;
    logic                   q;

    assign sig       = {fb, in_sig};
    assign ctrl_mask = {cfg_clk_mask, cfg_oe_mask, cfg_clr_mask};

    mc_pterm_array #(
        .N_SIG   (N_SIG),
        .N_TERMS (N_PT)
    ) u_sum (
        .sig  (sig),
        .mask (cfg_sum_mask),
        .term (sum_term)
    );

    mc_pterm_array #(
        .N_SIG   (N_SIG),
        .N_TERMS (N_CTRL)
    ) u_ctrl (
        .sig  (sig),
        .mask (ctrl_mask),
        .term (ctrl_term)
    );

    assign sum_or  = |(sum_term & cfg_sum_use);
    assign sum_pol = sum_or ^ cfg_invert;
    assign clr_act = cfg_clr_use & ctrl_term[CT_CLR];

    mc_storage u_store (
        .clk_g    (clk_g),
        .clk_term (ctrl_term[CT_CLK]),
        .clk_src  (clk_src_e'(cfg_clk_local)),
        .neg_edge (cfg_neg_edge),
        .mode     (store_mode_e'(cfg_toggle)),
        .d        (sum_pol),
        .clr      (clr_act),
        .q        (q)
    );

    mc_output u_out (
        .sum_pol  (sum_pol),
        .q        (q),
        .out_mode (out_mode_e'(cfg_registered)),
        .oe_use   (cfg_oe_use),
        .oe_term  (ctrl_term[CT_OE]),
        .fb_src   (fb_src_e'(cfg_fb_pin)),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .fb       (fb)
    );

    // Output enable is only ever dropped by its own term
    p_oe_forced_r10: assert property (
        @(posedge clk_g) !cfg_oe_use |-> pin_oe);

    // Combinational mode shows the array result directly
    p_comb_pass_r4: assert property (
        @(posedge clk_g) !cfg_registered |-> (pin_out == sum_pol));

endmodule

// File: tb/macrocell_pt_test.sv
`timescale 1ns/1ps
module macrocell_pt_test;

    localparam int N_IN  = 4;
    localparam int N_PT  = 8;
    localparam int N_SIG = N_IN + 1;
    localparam int NLIT  = 2 * N_SIG;

    logic                 clk_g = 1'b0;
    logic [N_IN-1:0]      in_sig;
    logic                 pin_in;
    logic [N_PT*NLIT-1:0] cfg_sum_mask;
    logic [N_PT-1:0]      cfg_sum_use;
    logic                 cfg_invert, cfg_registered, cfg_toggle, cfg_neg_edge;
    logic                 cfg_clk_local, cfg_clr_use, cfg_oe_use, cfg_fb_pin;
    logic [NLIT-1:0]      cfg_clk_mask, cfg_clr_mask, cfg_oe_mask;
    logic                 pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk_g = ~clk_g;

    macrocell_pt uut (
        .clk_g, .in_sig, .pin_in, .cfg_sum_mask, .cfg_sum_use, .cfg_invert,
        .cfg_registered, .cfg_toggle, .cfg_neg_edge, .cfg_clk_local,
        .cfg_clk_mask, .cfg_clr_use, .cfg_clr_mask, .cfg_oe_use,
        .cfg_oe_mask, .cfg_fb_pin, .pin_out, .pin_oe
    );

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic logic [NLIT-1:0] lit(input int s, input int neg);
        logic [NLIT-1:0] m;
        m = '0;
        m[2*s+neg] = 1'b1;
        return m;
    endfunction

    function automatic logic [N_PT*NLIT-1:0] hash_masks(input int seed);
        logic [N_PT*NLIT-1:0] m;
        m = '0;
        for (int k = 0; k < N_PT; k++)
            for (int j = 0; j < NLIT; j++)
                m[k*NLIT+j] = (((k*5 + j*3 + seed) % 7) < 2);
        return m;
    endfunction

    // Sum of products as the requirements define it
    function automatic logic model_sop(input logic [N_PT*NLIT-1:0] m,
                                       input logic [N_PT-1:0] en,
                                       input logic [N_SIG-1:0] s);
        logic r;
        r = 1'b0;
        for (int k = 0; k < N_PT; k++) begin
            logic p;
            p = 1'b1;
            for (int j = 0; j < NLIT; j++)
                if (m[k*NLIT+j]) p = p & (s[j/2] ^ logic'(j % 2));
            if (en[k]) r = r | p;
        end
        return r;
    endfunction

    task automatic at_pos();
        @(posedge clk_g);
        #1;
    endtask

    task automatic at_neg();
        @(negedge clk_g);
        #1;
    endtask

    task automatic base_cfg();
        cfg_sum_mask   = '0;
        cfg_sum_use    = '0;
        cfg_invert     = 1'b0;
        cfg_registered = 1'b0;
        cfg_toggle     = 1'b0;
        cfg_neg_edge   = 1'b0;
        cfg_clk_local  = 1'b0;
        cfg_clk_mask   = '0;
        cfg_clr_use    = 1'b0;
        cfg_clr_mask   = '0;
        cfg_oe_use     = 1'b0;
        cfg_oe_mask    = '0;
        cfg_fb_pin     = 1'b1;
    endtask

    // Registered setup: D mode, term 0 = in_sig[0], clear term = in_sig[3]
    task automatic reg_cfg();
        base_cfg();
        cfg_registered = 1'b1;
        cfg_clr_use    = 1'b1;
        cfg_clr_mask   = lit(3, 0);
        cfg_sum_mask[0 +: NLIT] = lit(0, 0);
        cfg_sum_use    = 8'h01;
    endtask

    // Clear held across one rising edge of clk_g
    task automatic do_clear(input string req);
        at_neg();
        in_sig[3] = 1'b1;
        #1 chk(pin_out, 1'b0, req, "register after clear asserted");
        at_pos();
        chk(pin_out, 1'b0, req, "register while clear held over edge");
        in_sig[3] = 1'b0;
    endtask

    task automatic sweep(input string req, input bit parity);
        for (int v = 0; v < 32; v++) begin
            logic e;
            in_sig = v[3:0];
            pin_in = v[4];
            #1;
            e = parity ? ^v[2:0] : model_sop(cfg_sum_mask, cfg_sum_use, v[4:0]);
            e = e ^ cfg_invert;
            chk(pin_out, e, req, $sformatf("sum in=%0d pin=%0d", v[3:0], v[4]));
        end
    endtask

    initial begin
        logic exp_q;
        in_sig = '0;
        pin_in = 1'b0;
        base_cfg();
        #7;
        // Reset-like state: no terms enabled, enable forced on
        chk(pin_out, 1'b0, "R2", "idle output with no terms");
        chk(pin_oe, 1'b1, "R10", "idle output enable");

        // R2, R3: disabled terms contribute nothing
        cfg_sum_mask = hash_masks(1);
        sweep("R2", 1'b0);
        cfg_invert = 1'b1;
        sweep("R3", 1'b0);

        // R1: an enabled empty term is constant 1
        cfg_invert = 1'b0;
        cfg_sum_mask = hash_masks(2);
        cfg_sum_mask[3*NLIT +: NLIT] = '0;
        cfg_sum_use = 8'b0000_1000;
        sweep("R1", 1'b0);

        // R1: odd parity of in_sig[2:0] from four minterms
        cfg_sum_mask = hash_masks(3);
        begin
            int codes [4] = '{1, 2, 4, 7};
            for (int t = 0; t < 4; t++) begin
                logic [NLIT-1:0] m;
                m = '0;
                for (int b = 0; b < 3; b++)
                    m = m | lit(b, ((codes[t] >> b) & 1) ? 0 : 1);
                cfg_sum_mask[t*NLIT +: NLIT] = m;
            end
        end
        cfg_sum_use = 8'h0F;
        sweep("R1", 1'b1);
        cfg_invert = 1'b1;
        sweep("R3", 1'b1);

        // R2, R4, R11: hashed masks with the pin as feedback
        cfg_invert = 1'b0;
        cfg_sum_mask = hash_masks(4);
        cfg_sum_use = 8'hB6;
        sweep("R2", 1'b0);
        cfg_sum_mask = hash_masks(6);
        cfg_sum_use = 8'h5D;
        cfg_invert = 1'b1;
        sweep("R4", 1'b0);

        // R5: D register on rising clk_g
        reg_cfg();
        in_sig = '0;
        pin_in = 1'b0;
        do_clear("R9");
        exp_q = 1'b0;
        begin
            logic [6:0] seq = 7'b1001011;
            for (int i = 0; i < 7; i++) begin
                at_neg();
                in_sig[0] = seq[i];
                #1 chk(pin_out, exp_q, "R5", "hold between edges");
                at_pos();
                exp_q = seq[i];
                chk(pin_out, exp_q, "R5", $sformatf("load step %0d", i));
            end
        end

        // R6: T behaviour
        cfg_toggle = 1'b1;
        do_clear("R9");
        exp_q = 1'b0;
        begin
            logic [5:0] seq = 6'b101101;
            for (int i = 0; i < 6; i++) begin
                at_neg();
                in_sig[0] = seq[i];
                at_pos();
                exp_q = exp_q ^ seq[i];
                chk(pin_out, exp_q, "R6", $sformatf("toggle step %0d", i));
            end
        end

        // R9: clear priority and disable
        cfg_toggle = 1'b0;
        at_neg();
        in_sig[0] = 1'b1;
        at_pos();
        chk(pin_out, 1'b1, "R5", "load before clear");
        at_neg();
        in_sig[3] = 1'b1;
        #1 chk(pin_out, 1'b0, "R9", "asynchronous clear mid cycle");
        at_pos();
        chk(pin_out, 1'b0, "R9", "clear beats edge 1");
        at_pos();
        chk(pin_out, 1'b0, "R9", "clear beats edge 2");
        in_sig[3] = 1'b0;
        at_pos();
        chk(pin_out, 1'b1, "R9", "load after clear release");
        at_neg();
        cfg_clr_use = 1'b0;
        in_sig[3] = 1'b1;
        #1 chk(pin_out, 1'b1, "R9", "disabled clear no effect");
        at_pos();
        chk(pin_out, 1'b1, "R9", "disabled clear over edge");
        in_sig[3] = 1'b0;
        cfg_clr_use = 1'b1;

        // R7: falling edge
        cfg_neg_edge = 1'b1;
        do_clear("R9");
        in_sig[0] = 1'b1;
        at_neg();
        chk(pin_out, 1'b1, "R7", "load on falling edge");
        in_sig[0] = 1'b0;
        at_pos();
        chk(pin_out, 1'b1, "R7", "rising edge ignored");
        at_neg();
        chk(pin_out, 1'b0, "R7", "second falling edge");

        // R8: local clock from in_sig[2]
        cfg_neg_edge = 1'b0;
        cfg_clk_mask = lit(2, 0);
        cfg_clk_local = 1'b1;
        in_sig[2] = 1'b0;
        do_clear("R9");
        in_sig[0] = 1'b1;
        at_pos();
        chk(pin_out, 1'b0, "R8", "shared clock ignored");
        in_sig[2] = 1'b1;
        #1 chk(pin_out, 1'b1, "R8", "local rising edge");
        in_sig[0] = 1'b0;
        #1 in_sig[2] = 1'b0;
        #1 chk(pin_out, 1'b1, "R8", "local falling edge ignored");
        in_sig[2] = 1'b1;
        #1 chk(pin_out, 1'b0, "R8", "second local rising edge");
        cfg_neg_edge = 1'b1;
        in_sig[0] = 1'b1;
        #1 in_sig[2] = 1'b0;
        #1 chk(pin_out, 1'b1, "R7", "local falling edge when inverted");

        // R11: register feedback, term 0 = complement of feedback
        reg_cfg();
        cfg_fb_pin = 1'b0;
        cfg_sum_mask[0 +: NLIT] = lit(N_IN, 1);
        in_sig = '0;
        do_clear("R9");
        exp_q = 1'b0;
        for (int i = 0; i < 4; i++) begin
            at_pos();
            exp_q = ~exp_q;
            chk(pin_out, exp_q, "R11", $sformatf("register feedback divide %0d", i));
        end

        // R11: pin feedback into a registered term
        cfg_fb_pin = 1'b1;
        cfg_sum_mask[0 +: NLIT] = lit(N_IN, 0);
        do_clear("R9");
        at_neg();
        pin_in = 1'b1;
        at_pos();
        chk(pin_out, 1'b1, "R11", "pin feedback high");
        at_neg();
        pin_in = 1'b0;
        at_pos();
        chk(pin_out, 1'b0, "R11", "pin feedback low");

        // R3: inversion before the register
        cfg_sum_mask[0 +: NLIT] = lit(0, 0);
        cfg_invert = 1'b1;
        do_clear("R9");
        at_neg();
        in_sig[0] = 1'b1;
        at_pos();
        chk(pin_out, 1'b0, "R3", "registered inverted high input");
        at_neg();
        in_sig[0] = 1'b0;
        at_pos();
        chk(pin_out, 1'b1, "R3", "registered inverted low input");

        // R10: output enable term
        cfg_oe_use = 1'b1;
        cfg_oe_mask = lit(1, 1) | lit(2, 0);
        for (int v = 0; v < 4; v++) begin
            in_sig[1] = v[0];
            in_sig[2] = v[1];
            #1 chk(pin_oe, ~v[0] & v[1], "R10", $sformatf("enable term code %0d", v));
        end
        cfg_oe_use = 1'b0;
        for (int v = 0; v < 4; v++) begin
            in_sig[1] = v[0];
            in_sig[2] = v[1];
            #1 chk(pin_oe, 1'b1, "R10", $sformatf("enable forced code %0d", v));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule